// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch for a Three-Slot VLIW Core

This block feeds a 24-bit very-long-instruction-word pipeline from an instruction memory that is only one byte wide. The memory takes an 8-bit byte address and returns one byte. The fetch unit issues one byte read in every clock cycle. Three consecutive reads, which together make one three-cycle pipeline stage, are joined into one instruction word. The block then presents that word with a single-cycle valid strobe and the instruction index it came from.

A one-hot phase machine steps through three states: `PH_HIGH` fetches the most significant byte, `PH_MIDDLE` the centre byte and `PH_LOW` the least significant byte. There are three named transitions. `ADV_HM` goes from `PH_HIGH` to `PH_MIDDLE`, `ADV_ML` from `PH_MIDDLE` to `PH_LOW`, and `WRAP_LH` from `PH_LOW` to `PH_HIGH`, which closes the instruction. Reset forces `PH_HIGH`. The address of the next byte is derived from registered state at the start of each cycle. The returned byte is captured on the falling clock edge, in the second half of that cycle.

The program counter counts whole instructions. Each instruction occupies three bytes, so 85 instructions (0 to 84) fit and the counter returns to 0 after 84. The execute stage redirects fetch with a taken-branch pulse and a target given as an instruction index. The fetch already under way is always completed, and the redirect takes effect at the next instruction boundary. In a pipeline where fetch, decode and execute each take one stage, this yields two branch delay slots: the instructions in decode and in fetch both issue.

Top module: `vliw_byte_fetch`

## Requirements
- R1: While reset is asserted, `mem_addr` is 0, `instr_valid` is 0, `instr_word` is 0 and `instr_pc` is 0. The first cycle after reset reads byte address 0.
- R2: Exactly one byte read is issued per cycle. Within one instruction the three addresses are B, B+1 and B+2 in consecutive cycles, where B = 3 × instruction index.
- R3: The byte read in `PH_HIGH` lands in `instr_word[23:16]`, the byte read in `PH_MIDDLE` in bits 15:8, and the byte read in `PH_LOW` in bits 7:0.
- R4: `instr_valid` is high for exactly one cycle in every three. It is asserted in the cycle after the `PH_LOW` read, together with the new `instr_word` and `instr_pc`.
- R5: With no branch, successive delivered words carry `instr_pc` values that increase by 1.
- R6: After instruction 84 the next instruction fetched is 0. `mem_addr` never exceeds 254.
- R7: A branch pulse seen while instruction N is being fetched lets N complete and be delivered. The next instruction delivered is the target, fetched from byte address 3 × target.
- R8: A branch pulse seen in the `PH_LOW` cycle of instruction N still redirects the fetch that follows N.
- R9: A pending branch takes priority over the wrap at instruction 84. A target above 84 is treated as 0.
- R10: If more than one branch pulse arrives during one instruction fetch, the target of the most recent pulse is used.
- R11: The byte captured is the value `mem_rdata` holds at the falling clock edge. Changes in the second half of the cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; address launched on rising edge, byte captured on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_taken | input | 1 | Taken-branch pulse from execute |
| br_target | input | 7 | Branch target as an instruction index |
| mem_rdata | input | 8 | Byte returned by the instruction memory |
| mem_addr | output | 8 | Byte address for the current read |
| instr_word | output | 24 | Assembled instruction word |
| instr_valid | output | 1 | One-cycle strobe marking a new instruction word |
| instr_pc | output | 7 | Instruction index of `instr_word` |

## Verification
A branch redirect and an instruction boundary can fall in the same cycle. This happens when the branch pulse arrives during the `PH_LOW` read. The same collision can also coincide with the wrap from instruction 84 to 0. The bench provokes the first case by raising the pulse exactly in the third byte cycle. It provokes the second by requesting a branch while instruction 84 is being fetched. In both cases it judges the result by the sequence of delivered `instr_pc` values and by `mem_addr` in the cycle after the boundary. The memory model also drives a corrupted byte in the second half of every cycle, so every word comparison also tests the falling-edge capture.

// File: rtl/vbf_pkg.sv
`timescale 1ns/1ps
package vbf_pkg;

    // Number of byte reads that make one instruction word.
    localparam int BYTES_PER_WORD = 3;

    // One-hot fetch phase; bit i selects byte lane i (lane 0 is the MSB).
    typedef enum logic [BYTES_PER_WORD-1:0] {
        PH_HIGH   = 3'b001,
        PH_MIDDLE = 3'b010,
        PH_LOW    = 3'b100
    } phase_e;

    localparam int OFF_W = $clog2(BYTES_PER_WORD);

endpackage

// File: rtl/vbf_phase_seq.sv
`timescale 1ns/1ps
module vbf_phase_seq
    import vbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output phase_e           phase,
    output logic [OFF_W-1:0] byte_off,
    output logic             last_cyc
);

    phase_e state_q;
    phase_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ADV_HM, ADV_ML, WRAP_LH.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_HIGH:   state_d = PH_MIDDLE;
            PH_MIDDLE: state_d = PH_LOW;
            PH_LOW:    state_d = PH_HIGH;
            default:   state_d = PH_HIGH;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        byte_off = '0;
        last_cyc = 1'b0;
        unique case (state_q)
            PH_HIGH: begin
                byte_off = OFF_W'(0);
            end
            PH_MIDDLE: begin
                byte_off = OFF_W'(1);
            end
            PH_LOW: begin
                byte_off = OFF_W'(2);
                last_cyc = 1'b1;
            end
            default: begin
                byte_off = '0;
            end
        endcase
    end

    assign phase = state_q;

    // R2: exactly one byte lane is active in every cycle.
    assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    // R2: the phase steps in a fixed order.
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW) |=> (state_q == PH_HIGH));

endmodule

// File: rtl/vbf_pc_ctrl.sv
`timescale 1ns/1ps
module vbf_pc_ctrl
    import vbf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PC_W    = 7,
    parameter int LAST_PC = 84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_cyc,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic              br_taken,
    input  logic [PC_W-1:0]   br_target,
    output logic [PC_W-1:0]   pc,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam logic [PC_W-1:0]   LAST    = PC_W'(LAST_PC);
    localparam logic [ADDR_W-1:0] MAX_ADR = ADDR_W'(LAST_PC * BYTES_PER_WORD + BYTES_PER_WORD - 1);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(BYTES_PER_WORD);

    logic [PC_W-1:0]   pc_q;
    logic [ADDR_W-1:0] base_q;
    logic              pend_q;
    logic [PC_W-1:0]   pend_tgt_q;

    logic              redirect;
    logic [PC_W-1:0]   raw_tgt;
    logic [PC_W-1:0]   sel_tgt;
    logic [ADDR_W-1:0] tgt_ext;
    logic [ADDR_W-1:0] tgt_base;

    // The newest request wins: a pulse in this cycle overrides a held one.
    always_comb begin
        redirect = br_taken | pend_q;
        raw_tgt  = br_taken ? br_target : pend_tgt_q;
        sel_tgt  = (raw_tgt > LAST) ? '0 : raw_tgt;
        tgt_ext  = ADDR_W'(sel_tgt);
        tgt_base = (tgt_ext << 1) + tgt_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= '0;
            base_q     <= '0;
            pend_q     <= 1'b0;
            pend_tgt_q <= '0;
        end else if (last_cyc) begin
            pend_q <= 1'b0;
            if (redirect) begin
                pc_q   <= sel_tgt;
                base_q <= tgt_base;
            end else if (pc_q == LAST) begin
                pc_q   <= '0;
                base_q <= '0;
            end else begin
                pc_q   <= pc_q + PC_W'(1);
                base_q <= base_q + STEP;
            end
        end else if (br_taken) begin
            pend_q     <= 1'b1;
            pend_tgt_q <= br_target;
        end
    end

    assign pc       = pc_q;
    assign mem_addr = base_q + ADDR_W'(byte_off);

    // R6: the address never runs past the last whole instruction.
    assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr <= MAX_ADR);

    // R6: the counter returns to 0 after the last instruction.
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cyc && !br_taken && !pend_q && pc_q == LAST) |=> (pc_q == '0));

    // R5: sequential advance by one instruction.
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cyc && !br_taken && !pend_q && pc_q != LAST) |=> (pc_q == $past(pc_q) + PC_W'(1)));

    // R8: a pulse in the last byte cycle redirects immediately.
    assert_late_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cyc && br_taken && br_target <= LAST) |=> (pc_q == $past(br_target)));

    // R7: the byte base stays three times the instruction index.
    assert_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        base_q == (ADDR_W'(pc_q) << 1) + ADDR_W'(pc_q));

    // R2: within one instruction, addresses rise by one per cycle.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_cyc) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

endmodule

// File: rtl/vbf_word_asm.sv
`timescale 1ns/1ps
module vbf_word_asm
    import vbf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PC_W   = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  phase_e                           phase,
    input  logic [DATA_W-1:0]                mem_rdata,
    input  logic [PC_W-1:0]                  pc,
    output logic [BYTES_PER_WORD*DATA_W-1:0] instr_word,
    output logic                             instr_valid,
    output logic [PC_W-1:0]                  instr_pc
);

    localparam int WORD_W = BYTES_PER_WORD * DATA_W;

    logic [DATA_W-1:0] lane_q [BYTES_PER_WORD];
    logic [WORD_W-1:0] packed_w;

    // One capture register per byte lane, loaded on the falling edge.
    for (genvar i = 0; i < BYTES_PER_WORD; i++) begin : g_lane
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[i] <= '0;
            end else if (phase[i]) begin
                lane_q[i] <= mem_rdata;
            end
        end
        assign packed_w[WORD_W-1-i*DATA_W -: DATA_W] = lane_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_word  <= '0;
            instr_valid <= 1'b0;
            instr_pc    <= '0;
        end else begin
            instr_valid <= (phase == PH_LOW);
            if (phase == PH_LOW) begin
                instr_word <= packed_w;
                instr_pc   <= pc;
            end
        end
    end

    // R4: the strobe follows the last byte cycle.
    assert_valid_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (phase == PH_HIGH));

    // R4: the strobe lasts exactly one cycle.
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);

    // R4: the word holds between strobes.
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && phase != PH_HIGH) |-> $stable(instr_word));

endmodule

// File: rtl/vliw_byte_fetch.sv
`timescale 1ns/1ps
module vliw_byte_fetch
    import vbf_pkg::*;
#(
    parameter  int ADDR_W    = 8,
    parameter  int DATA_W    = 8,
    localparam int WORD_W    = BYTES_PER_WORD * DATA_W,
    localparam int NUM_INSTR = (1 << ADDR_W) / BYTES_PER_WORD,
    localparam int LAST_PC   = NUM_INSTR - 1,
    localparam int PC_W      = $clog2(NUM_INSTR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_taken,
    input  logic [PC_W-1:0]   br_target,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] instr_word,
    output logic              instr_valid,
    output logic [PC_W-1:0]   instr_pc
);

    phase_e           phase;
    logic [OFF_W-1:0] byte_off;
    logic             last_cyc;
    logic [PC_W-1:0]  pc;

    vbf_phase_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .byte_off (byte_off),
        .last_cyc (last_cyc)
    );

    vbf_pc_ctrl #(
        .ADDR_W  (ADDR_W),
        .PC_W    (PC_W),
        .LAST_PC (LAST_PC)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_cyc  (last_cyc),
        .byte_off  (byte_off),
        .br_taken  (br_taken),
        .br_target (br_target),
        .pc        (pc),
        .mem_addr  (mem_addr)
    );

    vbf_word_asm #(
        .DATA_W (DATA_W),
        .PC_W   (PC_W)
    ) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .mem_rdata   (mem_rdata),
        .pc          (pc),
        .instr_word  (instr_word),
        .instr_valid (instr_valid),
        .instr_pc    (instr_pc)
    );

    // R1: reset holds every output at zero.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (mem_addr == '0 && !instr_valid && instr_word == '0 && instr_pc == '0));

endmodule

// File: tb/vliw_byte_fetch_test.sv
`timescale 1ns/1ps
module vliw_byte_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_taken = 1'b0;
    logic [6:0]  br_target = '0;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_addr;
    logic [23:0] instr_word;
    logic        instr_valid;
    logic [6:0]  instr_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vliw_byte_fetch uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .instr_word  (instr_word),
        .instr_valid (instr_valid),
        .instr_pc    (instr_pc)
    );

    // Memory model: correct byte in the first half of the cycle, corrupted byte in the second (R11).
    function automatic logic [7:0] mem_byte(input logic [7:0] a);
        return 8'(a * 8'd37 + 8'd11);
    endfunction

    function automatic logic [23:0] exp_word(input int p);
        logic [7:0] b;
        b = 8'(p * 3);
        return {mem_byte(b), mem_byte(b + 8'd1), mem_byte(b + 8'd2)};
    endfunction

    logic late = 1'b0;
    always @(negedge clk) begin
        #1 late = 1'b1;
    end
    always @(posedge clk) begin
        #1 late = 1'b0;
    end
    assign mem_rdata = late ? ~mem_byte(mem_addr) : mem_byte(mem_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4: the strobe interval is three cycles.
    int gap = 0;
    bit seen = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            gap  = 0;
            seen = 1'b0;
        end else if (instr_valid) begin
            if (seen) check(gap == 3, "R4 strobe interval", gap, 3);
            seen = 1'b1;
            gap  = 1;
        end else begin
            gap++;
        end
    end

    task automatic wait_valid(output bit found);
        found = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            #2;
            if (instr_valid) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_word(input int exp_pc, input string req);
        check(instr_pc == 7'(exp_pc), req, 32'(instr_pc), 32'(exp_pc));
        check(instr_word == exp_word(exp_pc), "R3/R11 word bytes", 32'(instr_word), 32'(exp_word(exp_pc)));
    endtask

    typedef struct packed {
        logic       take;
        logic [6:0] tgt;
        logic [6:0] exp;
    } row_t;

    localparam int NROWS = 17;
    localparam row_t VEC [NROWS] = '{
        '{1'b0, 7'd0,   7'd0},
        '{1'b1, 7'd10,  7'd1},
        '{1'b0, 7'd0,   7'd2},
        '{1'b0, 7'd0,   7'd10},
        '{1'b1, 7'd83,  7'd11},
        '{1'b0, 7'd0,   7'd12},
        '{1'b0, 7'd0,   7'd83},
        '{1'b0, 7'd0,   7'd84},
        '{1'b1, 7'd100, 7'd0},
        '{1'b0, 7'd0,   7'd1},
        '{1'b0, 7'd0,   7'd0},
        '{1'b1, 7'd83,  7'd1},
        '{1'b0, 7'd0,   7'd2},
        '{1'b1, 7'd20,  7'd83},
        '{1'b0, 7'd0,   7'd84},
        '{1'b0, 7'd0,   7'd20},
        '{1'b0, 7'd0,   7'd21}
    };

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
    endtask

    initial begin
        bit found;
        // R1: reset state.
        do_reset();
        check(mem_addr == 8'd0, "R1 addr in reset", 32'(mem_addr), 0);
        check(instr_valid == 1'b0, "R1 valid in reset", 32'(instr_valid), 0);
        check(instr_word == 24'd0, "R1 word in reset", 32'(instr_word), 0);
        check(instr_pc == 7'd0, "R1 pc in reset", 32'(instr_pc), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        check(mem_addr == 8'd0, "R1 first read address", 32'(mem_addr), 0);
        // R2: one read per cycle, consecutive addresses.
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk);
            #2;
            check(mem_addr == 8'(k), "R2 address sequence", 32'(mem_addr), 32'(k));
            if (k == 3) begin
                check(instr_valid == 1'b1, "R4 first strobe", 32'(instr_valid), 1);
                check_word(0, "R5 first pc");
            end
        end

        // Table walk: R5, R6, R7, R9.
        do_reset();
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int r = 0; r < NROWS; r++) begin
            wait_valid(found);
            check(found, "R4 strobe present", 32'(found), 1);
            check_word(int'(VEC[r].exp), "R5/R6/R7/R9 pc sequence");
            if (VEC[r].take) begin
                br_taken  = 1'b1;
                br_target = VEC[r].tgt;
                @(posedge clk);
                #2;
                br_taken = 1'b0;
            end
        end

        // R8: pulse in the last byte cycle of instruction 22.
        @(posedge clk);
        #2;
        @(posedge clk);
        #1;
        br_taken  = 1'b1;
        br_target = 7'd40;
        @(posedge clk);
        #2;
        br_taken = 1'b0;
        check(instr_valid == 1'b1, "R8 strobe at boundary", 32'(instr_valid), 1);
        check_word(22, "R8 current instruction");
        check(mem_addr == 8'd120, "R7 target byte address", 32'(mem_addr), 120);
        wait_valid(found);
        check_word(40, "R8 redirected instruction");

        // R10: two pulses during one fetch, newest wins.
        br_taken  = 1'b1;
        br_target = 7'd7;
        @(posedge clk);
        #2;
        br_target = 7'd9;
        @(posedge clk);
        #2;
        br_taken = 1'b0;
        wait_valid(found);
        check_word(41, "R10 in-flight instruction");
        wait_valid(found);
        check_word(9, "R10 latest target");

        // R1: reset in mid-run.
        do_reset();
        check(instr_valid == 1'b0 && mem_addr == 8'd0, "R1 mid-run reset",
              {23'd0, instr_valid, mem_addr}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule